// File: doc/BRIEF.md
# Masked Indexed Gather Engine

The engine fills a vector register from scattered memory locations. When a start pulse arrives it captures a base address, a vector of per-lane indices, a scale factor, a lane mask and a source vector. For every lane whose mask bit is set, it forms an address from the base and the scaled index and reads one element through a simple request/response read port. Each lane whose mask bit is clear keeps the matching element of the source vector. When the last read has returned, the engine raises `done` for one cycle. The merged vector stays on `result` until the next start.

Two mode bits choose the index width (32 or 64 bits) and the element width (32 or 64 bits). These two bits set how many lanes take part and how the result is laid out. A scale value other than 1, 2, 4 or 8 is rejected: the engine completes at once, sets `err` and issues no read.

Top module: `gather_engine`

## Requirements
- R1: With `idx_wide`=0, the index of lane j is `index_vec[32j+31:32j]`. It is sign-extended to 64 bits, multiplied by `scale` and added to `base`. The read address is this sum modulo 2^64.
- R2: With `idx_wide`=1, the index of lane j is `index_vec[64j+63:64j]`. It is used unchanged, multiplied by `scale` and added to `base`, modulo 2^64.
- R3: A `scale` value outside {1, 2, 4, 8} completes the operation with `err`=1 and no `rd_req`. In that case `result` holds the source vector in the format of the selected mode. A legal scale clears `err`.
- R4: An in-range lane with a clear mask bit is never read, and its result element equals the matching source element. An in-range lane with a set mask bit takes the returned read data.
- R5: With 32-bit indices and 32-bit elements there are 8 lanes. Lane j uses `mask[j]` and occupies `result[32j+31:32j]`.
- R6: With 64-bit indices and 32-bit elements there are 4 lanes. Lane j occupies `result[32j+31:32j]`, `result[255:128]` is zero, and `mask[7:4]` is ignored.
- R7: With 64-bit elements (either index width) there are 4 lanes. Lane j occupies `result[64j+63:64j]`, and `mask[7:4]` is ignored.
- R8: Reads are issued in ascending lane order. `rd_req` is a one-cycle pulse, and no new request is made until `rd_valid` has returned the data of the previous one.
- R9: `done` is a single-cycle pulse. It rises in the cycle after the last response, or in the cycle after start when there are no reads. `busy` is high from the cycle after start until `done`. A `start` during `busy` is ignored, and `result` does not change while idle.
- R10: After reset, `busy`, `done`, `err`, `rd_req` and `result` are all zero.
- R11: `rd_wide` equals the element width selection during each request. For 32-bit elements, only `rd_data[31:0]` is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| idx_wide | input | 1 | 1 selects 64-bit indices, 0 selects 32-bit indices |
| elem_wide | input | 1 | 1 selects 64-bit elements, 0 selects 32-bit elements |
| scale | input | 4 | Index multiplier; legal values 1, 2, 4, 8 |
| mask | input | 8 | Per-lane enable |
| base | input | 64 | Base address |
| index_vec | input | 256 | Packed per-lane indices |
| src_vec | input | 256 | Values for disabled lanes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation had an illegal scale |
| result | output | 256 | Merged vector |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 64 | Read address, valid with `rd_req` |
| rd_wide | output | 1 | Read element is 64 bits |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 64 | Read response data |

## Verification
The assertions assume a memory side that raises `rd_valid` at most once per request. They also assume the response never arrives in the same cycle as its request. The bench responder answers each pulse only after one to three whole cycles, so the engine is always waiting when data arrives. The assertions also assume that `start` is sampled only when the engine is idle, or that any `start` while busy is dropped. The bench pulses start only from idle, except in one deliberate test where start is raised mid-operation with conflicting inputs.

// File: rtl/gather_pkg.sv
package gather_pkg;
  parameter int GA_ADDR_W    = 64;
  parameter int GA_SLOT_W    = 32;
  parameter int GA_VEC_W     = 256;
  parameter int GA_SCALE_W   = 4;
  parameter int GA_MAX_LANES = GA_VEC_W / GA_SLOT_W;
  parameter int GA_LANE_W    = $clog2(GA_MAX_LANES);

  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_ISSUE = 2'd1,
    GS_WAIT  = 2'd2
  } gs_state_t;

  // legal multipliers are the powers of two up to eight
  function automatic logic scale_legal(input logic [GA_SCALE_W-1:0] s);
    return (s == GA_SCALE_W'(1)) || (s == GA_SCALE_W'(2)) ||
           (s == GA_SCALE_W'(4)) || (s == GA_SCALE_W'(8));
  endfunction

  function automatic logic [1:0] scale_log2(input logic [GA_SCALE_W-1:0] s);
    logic [1:0] r;
    case (s)
      GA_SCALE_W'(2): r = 2'd1;
      GA_SCALE_W'(4): r = 2'd2;
      GA_SCALE_W'(8): r = 2'd3;
      default:        r = 2'd0;
    endcase
    return r;
  endfunction

  // lanes taking part: all slots only for narrow index with narrow element
  function automatic logic [GA_MAX_LANES-1:0] lane_enable(input logic iw, input logic ew);
    logic [GA_MAX_LANES-1:0] r;
    if (!iw && !ew) r = '1;
    else            r = {{(GA_MAX_LANES/2){1'b0}}, {(GA_MAX_LANES/2){1'b1}}};
    return r;
  endfunction

  // pull one lane's index and widen it to an address-sized value
  function automatic logic [GA_ADDR_W-1:0] fetch_index(input logic [GA_VEC_W-1:0] iv,
                                                       input logic iw,
                                                       input logic [GA_LANE_W-1:0] lane);
    logic [GA_ADDR_W-1:0] r;
    logic [GA_SLOT_W-1:0] narrow;
    int li;
    if (iw) begin
      li = int'(lane[GA_LANE_W-2:0]);
      r  = iv[li*GA_ADDR_W +: GA_ADDR_W];
    end else begin
      li     = int'(lane);
      narrow = iv[li*GA_SLOT_W +: GA_SLOT_W];
      r      = {{(GA_ADDR_W-GA_SLOT_W){narrow[GA_SLOT_W-1]}}, narrow};
    end
    return r;
  endfunction

  // base plus shifted index; carry out of the top bit is dropped
  function automatic logic [GA_ADDR_W-1:0] lane_address(input logic [GA_ADDR_W-1:0] b,
                                                        input logic [GA_ADDR_W-1:0] idx,
                                                        input logic [1:0] sh);
    return b + (idx << sh);
  endfunction
endpackage

// File: rtl/gather_lane_pick.sv
module gather_lane_pick #(
  parameter int LANES = gather_pkg::GA_MAX_LANES,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic             found,
  output logic [LW-1:0]    lane
);
  // lowest pending lane wins: the last hit in a downward scan is kept
  always_comb begin
    found = 1'b0;
    lane  = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        lane  = LW'(i);
      end
    end
  end
endmodule

// File: rtl/gather_addr_gen.sv
module gather_addr_gen
  import gather_pkg::*;
#(
  parameter int ADDR_W = GA_ADDR_W,
  parameter int VEC_W  = GA_VEC_W,
  parameter int LW     = GA_LANE_W
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [VEC_W-1:0]  idx_vec,
  input  logic              idx_wide,
  input  logic [1:0]        shift,
  input  logic [LW-1:0]     lane,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] lane_idx;

  always_comb begin
    lane_idx = fetch_index(idx_vec, idx_wide, lane);
    addr     = lane_address(base, lane_idx, shift);
  end
endmodule

// File: rtl/gather_result_reg.sv
module gather_result_reg #(
  parameter int VEC_W  = gather_pkg::GA_VEC_W,
  parameter int SLOT_W = gather_pkg::GA_SLOT_W,
  localparam int NS    = VEC_W / SLOT_W,
  localparam int LW    = $clog2(NS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [VEC_W-1:0]  src,
  input  logic              half_zero,
  input  logic              wr,
  input  logic [LW-1:0]     wr_lane,
  input  logic              wr_wide,
  input  logic [2*SLOT_W-1:0] wr_data,
  output logic [VEC_W-1:0]  result
);
  for (genvar s = 0; s < NS; s++) begin : g_slot
    localparam int PAIR = s / 2;
    localparam bit ODD  = (s % 2) == 1;
    localparam bit HIGH = s >= NS / 2;

    logic                take_narrow;
    logic                take_wide;
    logic [SLOT_W-1:0]   wide_part;
    logic [SLOT_W-1:0]   slot_q;

    assign take_narrow = wr && !wr_wide && (int'(wr_lane) == s);
    assign take_wide   = wr &&  wr_wide && (int'(wr_lane) == PAIR);
    assign wide_part   = ODD ? wr_data[2*SLOT_W-1:SLOT_W] : wr_data[SLOT_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n)           slot_q <= '0;
      else if (init)        slot_q <= (half_zero && HIGH) ? '0 : src[s*SLOT_W +: SLOT_W];
      else if (take_narrow) slot_q <= wr_data[SLOT_W-1:0];
      else if (take_wide)   slot_q <= wide_part;
    end

    assign result[s*SLOT_W +: SLOT_W] = slot_q;
  end
endmodule

// File: rtl/gather_engine.sv
module gather_engine
  import gather_pkg::*;
#(
  parameter int ADDR_W  = GA_ADDR_W,
  parameter int VEC_W   = GA_VEC_W,
  parameter int SLOT_W  = GA_SLOT_W,
  parameter int SCALE_W = GA_SCALE_W,
  localparam int LANES  = VEC_W / SLOT_W,
  localparam int LW     = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               idx_wide,
  input  logic               elem_wide,
  input  logic [SCALE_W-1:0] scale,
  input  logic [LANES-1:0]   mask,
  input  logic [ADDR_W-1:0]  base,
  input  logic [VEC_W-1:0]   index_vec,
  input  logic [VEC_W-1:0]   src_vec,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [VEC_W-1:0]   result,
  output logic               rd_req,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_wide,
  input  logic               rd_valid,
  input  logic [2*SLOT_W-1:0] rd_data
);
  gs_state_t          state_q;
  logic [ADDR_W-1:0]  base_q;
  logic [VEC_W-1:0]   idx_q;
  logic               iw_q, ew_q, err_q;
  logic [1:0]         sh_q;
  logic [LANES-1:0]   pend_q, act_q;
  logic [LW-1:0]      lane_q, prev_lane_q;
  logic               have_prev_q;

  // named events
  logic               accept, issue_fire, resp_fire, finish;
  logic               pick_found;
  logic [LW-1:0]      pick_lane;
  logic [ADDR_W-1:0]  pick_addr;
  logic               start_legal;
  logic [LANES-1:0]   start_active;
  logic [LANES-1:0]   clear_bit;

  assign start_legal  = scale_legal(scale);
  assign start_active = start_legal ? (mask & lane_enable(idx_wide, elem_wide)) : '0;

  assign accept     = (state_q == GS_IDLE) && start;
  assign issue_fire = (state_q == GS_ISSUE) && pick_found;
  assign finish     = (state_q == GS_ISSUE) && !pick_found;
  assign resp_fire  = (state_q == GS_WAIT) && rd_valid;
  assign clear_bit  = LANES'(1) << lane_q;

  gather_lane_pick #(.LANES(LANES)) u_pick (
    .pend  (pend_q),
    .found (pick_found),
    .lane  (pick_lane)
  );

  gather_addr_gen #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .LW(LW)) u_addr (
    .base     (base_q),
    .idx_vec  (idx_q),
    .idx_wide (iw_q),
    .shift    (sh_q),
    .lane     (pick_lane),
    .addr     (pick_addr)
  );

  gather_result_reg #(.VEC_W(VEC_W), .SLOT_W(SLOT_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (accept),
    .src       (src_vec),
    .half_zero (idx_wide && !elem_wide),
    .wr        (resp_fire),
    .wr_lane   (lane_q),
    .wr_wide   (ew_q),
    .wr_data   (rd_data),
    .result    (result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= GS_IDLE;
      base_q      <= '0;
      idx_q       <= '0;
      iw_q        <= 1'b0;
      ew_q        <= 1'b0;
      sh_q        <= '0;
      pend_q      <= '0;
      act_q       <= '0;
      lane_q      <= '0;
      err_q       <= 1'b0;
      prev_lane_q <= '0;
      have_prev_q <= 1'b0;
    end else begin
      case (state_q)
        GS_IDLE: if (accept) begin
          state_q     <= GS_ISSUE;
          base_q      <= base;
          idx_q       <= index_vec;
          iw_q        <= idx_wide;
          ew_q        <= elem_wide;
          sh_q        <= scale_log2(scale);
          pend_q      <= start_active;
          act_q       <= start_active;
          err_q       <= !start_legal;
          have_prev_q <= 1'b0;
        end
        GS_ISSUE: begin
          if (issue_fire) begin
            state_q     <= GS_WAIT;
            lane_q      <= pick_lane;
            prev_lane_q <= pick_lane;
            have_prev_q <= 1'b1;
          end else begin
            state_q <= GS_IDLE;
          end
        end
        GS_WAIT: if (resp_fire) begin
          pend_q  <= pend_q & ~clear_bit;
          state_q <= GS_ISSUE;
        end
        default: state_q <= GS_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != GS_IDLE);
  assign done    = finish;
  assign err     = err_q;
  assign rd_req  = issue_fire;
  assign rd_addr = pick_addr;
  assign rd_wide = ew_q;

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> !rd_req); // R8
  AST_ASCENDING_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_fire && have_prev_q) |-> (pick_lane > prev_lane_q)); // R8
  AST_READ_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> act_q[pick_lane]); // R4
  AST_BAD_SCALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && err_q) |-> !rd_req); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R9
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && iw_q && !ew_q) |-> (result[VEC_W-1:VEC_W/2] == '0)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result)); // R9
endmodule

// File: tb/gather_engine_bench.sv
module gather_engine_bench;
  typedef struct packed {
    logic        iw;
    logic        ew;
    logic [3:0]  sc;
    logic [7:0]  mk;
    logic [63:0] bs;
    logic [31:0] seed;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'd4, 8'hFF, 64'h0000_1000_0000_0000, 32'h0000_0010, 2'd1}, // R1 R5
    '{1'b0, 1'b0, 4'd1, 8'hA5, 64'h0000_0000_8000_0000, 32'h8000_0003, 2'd2}, // R4
    '{1'b0, 1'b1, 4'd8, 8'hFF, 64'h0000_0040_0000_1000, 32'h1234_5678, 2'd1}, // R7
    '{1'b1, 1'b1, 4'd2, 8'h0D, 64'hFFFF_0000_0000_0000, 32'h0BAD_F00D, 2'd3}, // R2 R7
    '{1'b1, 1'b0, 4'd4, 8'hF6, 64'h0000_0000_0010_0000, 32'h7777_0001, 2'd2}, // R6
    '{1'b0, 1'b0, 4'd2, 8'h80, 64'h0000_0000_0000_2000, 32'h4000_0000, 2'd1}, // R5
    '{1'b0, 1'b0, 4'd8, 8'h00, 64'h0000_0000_0000_3000, 32'h0000_0001, 2'd1}, // R4
    '{1'b0, 1'b0, 4'd3, 8'hFF, 64'h0000_0000_0000_4000, 32'h0000_0002, 2'd1}, // R3
    '{1'b1, 1'b1, 4'd0, 8'hFF, 64'h0000_0000_0000_5000, 32'h0000_0003, 2'd1}, // R3
    '{1'b0, 1'b1, 4'd1, 8'h0F, 64'h0000_0000_0000_0004, 32'hF000_0000, 2'd2}  // R1 wrap
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         idx_wide = 1'b0;
  logic         elem_wide = 1'b0;
  logic [3:0]   scale = 4'd1;
  logic [7:0]   mask = '0;
  logic [63:0]  base = '0;
  logic [255:0] index_vec = '0;
  logic [255:0] src_vec = '0;
  logic         busy, done, err, rd_req, rd_wide;
  logic [255:0] result;
  logic [63:0]  rd_addr;
  logic         rd_valid = 1'b0;
  logic [63:0]  rd_data = '0;

  gather_engine u_gather_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .idx_wide(idx_wide),
    .elem_wide(elem_wide), .scale(scale), .mask(mask), .base(base),
    .index_vec(index_vec), .src_vec(src_vec), .busy(busy), .done(done),
    .err(err), .result(result), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_wide(rd_wide), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial forever #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cur_lat = 1;
  int rec_n = 0;
  logic [63:0] rec_addr [8];
  logic        rec_wide [8];

  logic [255:0] exp_res;
  logic [63:0]  exp_addr [8];
  int           exp_n;
  logic         exp_err;

  function automatic logic [63:0] mdata(input logic [63:0] a);
    return {a[31:0] + 32'h1111_1111, a[63:32] ^ a[31:0] ^ 32'hC3C3_5A5A};
  endfunction

  function automatic logic [255:0] make_idx(input logic [31:0] seed);
    logic [255:0] v;
    for (int s = 0; s < 8; s++) v[32*s +: 32] = seed + 32'(s) * 32'h9E37_79B9;
    return v;
  endfunction

  function automatic logic [255:0] make_src(input logic [31:0] seed);
    logic [255:0] v;
    for (int s = 0; s < 8; s++) v[32*s +: 32] = ~seed ^ (32'(s) * 32'h0101_0101);
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model written from the requirement text
  task automatic model(input logic iw, input logic ew, input logic [3:0] sc,
                       input logic [7:0] mk, input logic [63:0] bs,
                       input logic [255:0] iv, input logic [255:0] sv);
    int lanes;
    bit legal;
    longint signed ix;
    logic signed [31:0] n32;
    logic [63:0] a;
    lanes   = (!iw && !ew) ? 8 : 4;
    legal   = (sc == 4'd1) || (sc == 4'd2) || (sc == 4'd4) || (sc == 4'd8);
    exp_err = !legal;
    exp_res = '0;
    exp_n   = 0;
    for (int j = 0; j < lanes; j++) begin
      if (legal && mk[j]) begin
        if (iw) ix = iv[64*j +: 64];
        else begin
          n32 = iv[32*j +: 32];
          ix  = n32;
        end
        a = bs + 64'(ix) * 64'(sc);
        exp_addr[exp_n] = a;
        exp_n++;
        if (ew) exp_res[64*j +: 64] = mdata(a);
        else    exp_res[32*j +: 32] = mdata(a)[31:0];
      end else begin
        if (ew) exp_res[64*j +: 64] = sv[64*j +: 64];
        else    exp_res[32*j +: 32] = sv[32*j +: 32];
      end
    end
  endtask

  // memory responder: answers each request after cur_lat cycles
  initial begin
    logic [63:0] a;
    forever begin
      @(negedge clk);
      while (rd_req) begin
        a = rd_addr;
        if (rec_n < 8) begin
          rec_addr[rec_n] = a;
          rec_wide[rec_n] = rd_wide;
        end
        rec_n++;
        repeat (cur_lat) @(negedge clk);
        rd_valid = 1'b1;
        rd_data  = mdata(a);
        @(negedge clk);
        rd_valid = 1'b0;
      end
    end
  end

  task automatic wait_done(output bit ok);
    int n = 0;
    ok = 1'b1;
    while (!done) begin
      @(negedge clk);
      n++;
      if (n > 2000) begin
        ok = 1'b0;
        break;
      end
    end
  endtask

  task automatic run_op(input logic iw, input logic ew, input logic [3:0] sc,
                        input logic [7:0] mk, input logic [63:0] bs,
                        input logic [31:0] seed, input int lat, input bit poke);
    bit ok;
    @(negedge clk);
    idx_wide = iw; elem_wide = ew; scale = sc; mask = mk; base = bs;
    index_vec = make_idx(seed); src_vec = make_src(seed);
    cur_lat = lat;
    rec_n = 0;
    model(iw, ew, sc, mk, bs, index_vec, src_vec);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: start raised while busy with conflicting inputs must be dropped
      @(negedge clk);
      chk(busy == 1'b1, "R9 busy during op", 256'(busy), 256'(1));
      start = 1'b1; mask = 8'hFF; scale = 4'd8; base = '1;
      index_vec = '1; src_vec = '0; idx_wide = ~iw;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(ok);
    chk(ok, "R9 done reached", 256'(ok), 256'(1));
    chk(err == exp_err, "R3 err flag", 256'(err), 256'(exp_err));
    chk(result == exp_res, "R4 merged result", result, exp_res);
    chk(rec_n == exp_n, "R8 read count", 256'(rec_n), 256'(exp_n));
    for (int k = 0; k < exp_n && k < rec_n && k < 8; k++) begin
      chk(rec_addr[k] == exp_addr[k], iw ? "R2 lane address" : "R1 lane address",
          256'(rec_addr[k]), 256'(exp_addr[k]));
      chk(rec_wide[k] == ew, "R11 read width", 256'(rec_wide[k]), 256'(ew));
    end
    if (iw && !ew)
      chk(result[255:128] == '0, "R6 upper half zero", result, exp_res);
    @(negedge clk);
    chk(!done && !busy, "R9 done one cycle", 256'({done, busy}), 256'(0));
    repeat (3) @(negedge clk);
    chk(result == exp_res, "R9 result held idle", result, exp_res);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(!busy && !done && !err && !rd_req, "R10 reset flags",
        256'({busy, done, err, rd_req}), 256'(0));
    chk(result == '0, "R10 reset result", result, '0);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i].iw, VECS[i].ew, VECS[i].sc, VECS[i].mk, VECS[i].bs,
             VECS[i].seed, int'(VECS[i].lat), 1'b0);

    // R9: start during busy ignored
    run_op(1'b0, 1'b0, 4'd4, 8'h3C, 64'h0000_0000_0001_0000, 32'h5555_0000, 3, 1'b1);
    // R8: lanes issued in ascending order with sparse high mask, long latency
    run_op(1'b1, 1'b1, 4'd8, 8'h0A, 64'h0000_0000_0000_0100, 32'hFFFF_FFF0, 3, 1'b0);
    // R3: legal scale after an illegal one clears err
    run_op(1'b0, 1'b0, 4'd5, 8'hFF, 64'h10, 32'h1, 1, 1'b0);
    run_op(1'b0, 1'b0, 4'd1, 8'h01, 64'h10, 32'h1, 1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule